// File: doc/BRIEF.md
# Power Mode Control Unit

This unit sits beside a small 8-bit processor core. It holds the eight-bit power control register and moves the core between three operating conditions: running, idle and power-down. In idle the processor clock stops and the peripheral clock keeps running. In power-down both clocks stop and the oscillator is switched off. The unit also keeps a power-off flag, which records that the supply came up from nothing. It keeps a watchdog-load-enable flag as well, which the watchdog timer block reads and which clears when that timer is reloaded.

Software enters a low-power mode by writing the mode bits through the register port. Any enabled external interrupt pin held low ends idle. Power-down ends only through a level-sensitive, enabled external interrupt. While that pin is held low the oscillator restarts and counts a warm-up delay. Once the delay has run out, releasing the pin high completes the exit. When reset arrives during idle, a RAM write-inhibit output covers the cycle before the reset takes hold.

Top module: `pmu_top`

## Requirements
- R1: Under `rst` or `por`, every register bit except bit 5 clears, the register reads 0x00 apart from bit 5, `cpu_clk_en`, `per_clk_en` and `osc_en` are 1, and `ram_wr_inhibit` is 0 once reset is released.
- R2: `por` sets register bit 5 (power-off flag). `rst` alone leaves bit 5 unchanged. A software write sets or clears bit 5.
- R3: A write with bit 1 (power-down) and bit 0 (idle) both set while `wdog_en` is 1 stores bit 1 = 1 and bit 0 = 0, and power-down is entered.
- R4: While `wdog_en` is 0, a write does not change bit 1, and the clocks stay enabled.
- R5: Bit 4 (watchdog load enable) is written by software and mirrored on `wle`. A `wdog_load` pulse clears it, and the pulse wins over a write in the same cycle.
- R6: Two clock edges after a write that sets bit 0 alone, `cpu_clk_en` is 0 and `per_clk_en` is 1.
- R7: The clock edge after bit 1 becomes set, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0.
- R8: In idle, an external interrupt pin that is low and whose `irq_en` bit is 1, in either trigger mode, returns the unit to run at the next edge and clears bit 0. A pin whose enable is 0 is ignored.
- R9: In power-down, only a pin with `irq_en` = 1 and `irq_level` = 1 that is sampled low wakes the unit. `osc_en` rises at the edge that first sees that pin low. A pin in edge mode, or one that is disabled, leaves `osc_en` at 0.
- R10: The exit from power-down completes only after the wake pin has been sampled low on WARM_CYCLES+1 consecutive edges (17 by default) and is then sampled high. At that point the clocks return and bit 1 clears. A release after fewer low edges turns the oscillator off again, and the unit stays in power-down.
- R11: `ram_wr_inhibit` is 1 exactly while `rst` is high and the unit is in idle. It is 0 while `rst` is high in run.
- R12: Bits 7, 6, 3 and 2 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; keeps the power-off flag |
| por | input | 1 | Power-on indication; resets everything and sets the power-off flag |
| sfr_we | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data |
| wdog_en | input | 1 | Watchdog enable pin; power-down bit is writable only when 1 |
| wdog_load | input | 1 | Watchdog reload strobe; clears the load-enable flag |
| ext_irq_n | input | N_IRQ | External interrupt pins, active low |
| irq_en | input | N_IRQ | Per-pin interrupt enable |
| irq_level | input | N_IRQ | Per-pin trigger mode, 1 = level-sensitive |
| wle | output | 1 | Watchdog load enable flag, to the timer block |
| cpu_clk_en | output | 1 | Processor clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator run enable |
| ram_wr_inhibit | output | 1 | Blocks internal RAM writes while reset ends idle |

## Verification
The assertions assume that the interrupt pins, the enables and `wdog_en` change only away from the rising clock edge, and that `por` is applied once at start-up before any check is live. The bench drives every input on the falling edge and holds `por` together with `rst` for the first cycles. It changes the trigger-mode and enable settings only while the wake pins are high, so that no wake condition appears or vanishes through a configuration change rather than a pin change.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    typedef enum logic [2:0] {
        PM_RUN   = 3'd0,
        PM_IDLE  = 3'd1,
        PM_STOP  = 3'd2,
        PM_WARM  = 3'd3,
        PM_READY = 3'd4
    } pm_state_e;

    typedef struct packed {
        logic dbl_baud;
        logic fe_sel;
        logic pof;
        logic wle;
        logic gf1;
        logic gf0;
        logic pd;
        logic idl;
    } pcon_t;

    function automatic logic in_powerdown(input pm_state_e s);
        return (s == PM_STOP) || (s == PM_WARM) || (s == PM_READY);
    endfunction

endpackage

// File: rtl/pmu_reg.sv
module pmu_reg
    import pmu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic       wdog_en,
    input  logic       wdog_load,
    input  logic       clr_idl,
    input  logic       clr_pd,
    output pcon_t      q
);
    pcon_t wr;

    always_comb begin
        wr     = pcon_t'(wdata);
        wr.pd  = wdog_en ? wdata[1] : q.pd;
        wr.idl = wdata[0] & ~(wdog_en & wdata[1]);
    end

    always_ff @(posedge clk) begin
        if (por) begin
            q     <= '0;
            q.pof <= 1'b1;
        end else if (rst) begin
            q     <= '0;
            q.pof <= q.pof;
        end else begin
            if (we)
                q <= wr;
            if (wdog_load)
                q.wle <= 1'b0;
            if (clr_idl)
                q.idl <= 1'b0;
            if (clr_pd)
                q.pd <= 1'b0;
        end
    end

    AST_PD_NEEDS_WDEN: assert property (@(posedge clk) disable iff (rst || por)
        $rose(q.pd) |-> $past(wdog_en && we)) else $error("pd set without enable"); // R4

    AST_PD_OVER_IDLE: assert property (@(posedge clk) disable iff (rst || por)
        (we && wdata[1] && wdata[0] && wdog_en && !clr_pd) |=> (q.pd && !q.idl))
        else $error("idle not suppressed"); // R3

    AST_WLE_CLEARS: assert property (@(posedge clk) disable iff (rst || por)
        wdog_load |=> !q.wle) else $error("wle survived reload"); // R5

endmodule

// File: rtl/pmu_wake.sv
module pmu_wake #(
    parameter int N_IRQ = 2
) (
    input  logic [N_IRQ-1:0] ext_irq_n,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_level,
    output logic             any_low,
    output logic             lvl_low
);
    logic [N_IRQ-1:0] act;
    logic [N_IRQ-1:0] act_lvl;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_pin
        assign act[i]     = irq_en[i] & ~ext_irq_n[i];
        assign act_lvl[i] = act[i] & irq_level[i];
    end

    assign any_low = |act;
    assign lvl_low = |act_lvl;

endmodule

// File: rtl/pmu_seq.sv
module pmu_seq
    import pmu_pkg::*;
#(
    parameter int WARM_CYCLES = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      por,
    input  logic      pd_bit,
    input  logic      idl_bit,
    input  logic      any_low,
    input  logic      lvl_low,
    output pm_state_e state,
    output logic      clr_idl,
    output logic      clr_pd,
    output logic      cpu_clk_en,
    output logic      per_clk_en,
    output logic      osc_en
);
    localparam int CW = $clog2(WARM_CYCLES + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(WARM_CYCLES - 1);

    pm_state_e      nxt;
    logic [CW-1:0]  cnt;

    always_comb begin
        nxt     = state;
        clr_idl = 1'b0;
        clr_pd  = 1'b0;
        unique case (state)
            PM_RUN: begin
                if (pd_bit)       nxt = PM_STOP;
                else if (idl_bit) nxt = PM_IDLE;
            end
            PM_IDLE: begin
                if (pd_bit) nxt = PM_STOP;
                else if (any_low) begin
                    nxt     = PM_RUN;
                    clr_idl = 1'b1;
                end
            end
            PM_STOP: if (lvl_low) nxt = PM_WARM;
            PM_WARM: begin
                if (!lvl_low)             nxt = PM_STOP;
                else if (cnt == CNT_LAST) nxt = PM_READY;
            end
            PM_READY: begin
                if (!lvl_low) begin
                    nxt     = PM_RUN;
                    clr_pd  = 1'b1;
                    clr_idl = 1'b1;
                end
            end
            default: nxt = PM_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || por) begin
            state <= PM_RUN;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == PM_WARM && nxt == PM_WARM)
                cnt <= cnt + 1'b1;
            else
                cnt <= '0;
        end
    end

    assign cpu_clk_en = (state == PM_RUN);
    assign per_clk_en = (state == PM_RUN) || (state == PM_IDLE);
    assign osc_en     = (state != PM_STOP);

    AST_READY_AFTER_WARM: assert property (@(posedge clk) disable iff (rst || por)
        (state == PM_READY) |-> $past(state == PM_WARM || state == PM_READY))
        else $error("ready without warm-up"); // R10

endmodule

// File: rtl/pmu_top.sv
module pmu_top
    import pmu_pkg::*;
#(
    parameter int N_IRQ       = 2,
    parameter int WARM_CYCLES = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por,
    input  logic             sfr_we,
    input  logic [7:0]       sfr_wdata,
    output logic [7:0]       sfr_rdata,
    input  logic             wdog_en,
    input  logic             wdog_load,
    input  logic [N_IRQ-1:0] ext_irq_n,
    input  logic [N_IRQ-1:0] irq_en,
    input  logic [N_IRQ-1:0] irq_level,
    output logic             wle,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             ram_wr_inhibit
);
    pcon_t     pcon;
    pm_state_e state;
    logic      clr_idl, clr_pd, any_low, lvl_low;

    pmu_reg u_reg (
        .clk(clk), .rst(rst), .por(por), .we(sfr_we), .wdata(sfr_wdata),
        .wdog_en(wdog_en), .wdog_load(wdog_load),
        .clr_idl(clr_idl), .clr_pd(clr_pd), .q(pcon)
    );

    pmu_wake #(.N_IRQ(N_IRQ)) u_wake (
        .ext_irq_n(ext_irq_n), .irq_en(irq_en), .irq_level(irq_level),
        .any_low(any_low), .lvl_low(lvl_low)
    );

    pmu_seq #(.WARM_CYCLES(WARM_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .por(por), .pd_bit(pcon.pd), .idl_bit(pcon.idl),
        .any_low(any_low), .lvl_low(lvl_low), .state(state),
        .clr_idl(clr_idl), .clr_pd(clr_pd),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en)
    );

    assign sfr_rdata      = pcon;
    assign wle            = pcon.wle;
    assign ram_wr_inhibit = rst && (state == PM_IDLE);

    AST_PD_STOPS_CLOCKS: assert property (@(posedge clk) disable iff (rst || por)
        $rose(pcon.pd) |=> (!cpu_clk_en && !per_clk_en && !osc_en))
        else $error("clocks alive in power-down"); // R7

    AST_IDLE_GATES_CPU: assert property (@(posedge clk) disable iff (rst || por)
        ($rose(pcon.idl) && !pcon.pd) |=> (!cpu_clk_en && per_clk_en))
        else $error("idle clock gating wrong"); // R6

    AST_EXIT_ON_RELEASE: assert property (@(posedge clk) disable iff (rst || por)
        ($rose(cpu_clk_en) && $past(!per_clk_en)) |-> $past(!lvl_low))
        else $error("power-down exit while pin low"); // R10

    AST_PD_EXIT_CLEARS_BIT: assert property (@(posedge clk) disable iff (rst || por)
        ($rose(cpu_clk_en) && $past(!per_clk_en)) |-> !pcon.pd)
        else $error("pd bit left set after exit"); // R10

endmodule

// File: tb/tb_pmu_top.sv
module tb_pmu_top;
    logic       clk = 1'b0;
    logic       rst, por, sfr_we, wdog_en, wdog_load;
    logic [7:0] sfr_wdata, sfr_rdata;
    logic [1:0] ext_irq_n, irq_en, irq_level;
    logic       wle, cpu_clk_en, per_clk_en, osc_en, ram_wr_inhibit;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    pmu_top dut (
        .clk(clk), .rst(rst), .por(por), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .wdog_en(wdog_en), .wdog_load(wdog_load),
        .ext_irq_n(ext_irq_n), .irq_en(irq_en), .irq_level(irq_level),
        .wle(wle), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .ram_wr_inhibit(ram_wr_inhibit)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic clocks(input string req, input logic c, input logic p, input logic o);
        chk(req, {5'd0, cpu_clk_en, per_clk_en, osc_en}, {5'd0, c, p, o});
    endtask

    task automatic wr(input logic [7:0] d);
        sfr_we = 1'b1; sfr_wdata = d;
        @(negedge clk);
        sfr_we = 1'b0;
    endtask

    task automatic pulse_rst();
        rst = 1'b1; @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset value", sfr_rdata, 8'h20);
        clocks("R1 reset clocks", 1, 1, 1);
        chk("R1 inhibit", {7'd0, ram_wr_inhibit}, 8'h00);
        chk("R2 por sets flag", {7'd0, sfr_rdata[5]}, 8'h01);
    endtask

    task automatic t_pof();
        wr(8'h2C);
        pulse_rst();
        chk("R2 rst keeps flag", sfr_rdata, 8'h20);
        wr(8'h00);
        chk("R2 sw clears flag", sfr_rdata, 8'h00);
        pulse_rst();
        chk("R2 rst keeps cleared flag", sfr_rdata, 8'h00);
    endtask

    task automatic t_general();
        wr(8'hCC);
        chk("R12 general bits", sfr_rdata, 8'hCC);
        wr(8'h00);
        chk("R12 general bits clear", sfr_rdata, 8'h00);
    endtask

    task automatic t_wle();
        wr(8'h10);
        chk("R5 wle set", {sfr_rdata[4], wle}, {1'b1, 1'b1});
        wdog_load = 1'b1; @(negedge clk); wdog_load = 1'b0;
        chk("R5 wle cleared by load", {sfr_rdata[4], wle}, 8'h00);
        wdog_load = 1'b1; wr(8'h10); wdog_load = 1'b0;
        chk("R5 load beats write", {7'd0, wle}, 8'h00);
    endtask

    task automatic t_pd_blocked();
        wdog_en = 1'b0;
        wr(8'h02);
        chk("R4 pd write ignored", sfr_rdata, 8'h00);
        @(negedge clk);
        clocks("R4 clocks stay", 1, 1, 1);
        wdog_en = 1'b1;
    endtask

    task automatic t_idle();
        irq_en = 2'b00; irq_level = 2'b00;
        wr(8'h01);
        @(negedge clk);
        clocks("R6 idle clocks", 0, 1, 1);
        chk("R6 idle bit", sfr_rdata, 8'h01);
        ext_irq_n[0] = 1'b0;
        repeat (3) @(negedge clk);
        clocks("R8 disabled pin ignored", 0, 1, 1);
        ext_irq_n[0] = 1'b1;
        irq_en = 2'b01;
        @(negedge clk);
        ext_irq_n[0] = 1'b0;
        @(negedge clk);
        clocks("R8 edge-mode wake from idle", 1, 1, 1);
        chk("R8 idle bit cleared", sfr_rdata, 8'h00);
        ext_irq_n[0] = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_ram_inhibit();
        rst = 1'b1;
        #1;
        chk("R11 no inhibit in run", {7'd0, ram_wr_inhibit}, 8'h00);
        @(negedge clk); rst = 1'b0;
        wr(8'h01);
        @(negedge clk);
        rst = 1'b1;
        #1;
        chk("R11 inhibit in idle", {7'd0, ram_wr_inhibit}, 8'h01);
        @(negedge clk); rst = 1'b0;
        chk("R11 inhibit drops", {7'd0, ram_wr_inhibit}, 8'h00);
        clocks("R11 run after reset", 1, 1, 1);
    endtask

    task automatic hold_low(input int n);
        ext_irq_n[1] = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_powerdown();
        irq_en = 2'b00; irq_level = 2'b00;
        wr(8'h03);
        chk("R3 pd wins", sfr_rdata, 8'h02);
        @(negedge clk);
        clocks("R7 pd clocks off", 0, 0, 0);
        irq_en = 2'b10; irq_level = 2'b00;
        hold_low(20);
        clocks("R9 edge-mode pin ignored", 0, 0, 0);
        ext_irq_n[1] = 1'b1; @(negedge clk);
        irq_en = 2'b00; irq_level = 2'b10;
        hold_low(20);
        clocks("R9 disabled pin ignored", 0, 0, 0);
        ext_irq_n[1] = 1'b1; @(negedge clk);
        irq_en = 2'b10; irq_level = 2'b10;
        hold_low(1);
        clocks("R9 oscillator restarts", 0, 0, 1);
        repeat (15) @(negedge clk);
        ext_irq_n[1] = 1'b1; @(negedge clk);
        clocks("R10 early release stays down", 0, 0, 0);
        chk("R10 pd still set", sfr_rdata, 8'h02);
        hold_low(17);
        clocks("R10 no exit while low", 0, 0, 1);
        ext_irq_n[1] = 1'b1; @(negedge clk);
        clocks("R10 exit on release", 1, 1, 1);
        chk("R10 pd bit cleared", sfr_rdata, 8'h00);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        rst = 1'b1; por = 1'b1; sfr_we = 1'b0; sfr_wdata = 8'h00;
        wdog_en = 1'b1; wdog_load = 1'b0;
        ext_irq_n = 2'b11; irq_en = 2'b00; irq_level = 2'b00;
        repeat (3) @(negedge clk);
        por = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pof();
        t_general();
        t_wle();
        t_pd_blocked();
        t_idle();
        t_ram_inhibit();
        t_powerdown();
        finish_run();
    end
endmodule